// File: doc/BRIEF.md
# Class Score Summation and Arrhythmia Decision Stage

This block is the back end of a probabilistic-network heartbeat classifier. It takes 22 unsigned activation values, one per stored template, from the hidden layer. It adds them into seven per-class sums. Each template belongs to exactly one class, so the grouping needs only adders and no multipliers. The sum of the seven class sums is the grand total. Every class sum is divided by that total to give a fixed-point share between 0 and 1. The class with the largest share is reported as a 3-bit code, together with a valid strobe.

One activation vector can be presented on every clock cycle. The sum stage, a fraction-wise pipelined divider and a registered decision stage give a fixed latency with no back-pressure. When every activation is zero, the block does not divide. It reports an all-zero score set and raises a separate flag.

Top module: `pnn_class_decide`

## Requirements
- R1: Activation lane k (0-based, lane k in bits [16k+15:16k] of `in_act`) adds into exactly one class: lane 0 into class 0 (normal), lanes 1–6 into class 1 (premature ventricular), lanes 7–8 into class 2 (atrial premature), lanes 9–11 into class 3 (left bundle block), lanes 12–15 into class 4 (right bundle block), lanes 16–19 into class 5 (paced), and lanes 20–21 into class 6 (fusion).
- R2: With class sums S_j and total T > 0, score j equals floor(S_j·4096 / T). It is 13 bits wide with 12 fraction bits, and score j sits in bits [13j+12:13j] of `out_score`. A score never exceeds 4096.
- R3: `out_class` is the index of the largest score, and the codes 0–6 follow the class order of R1.
- R4: When two or more scores share the maximum value, `out_class` is the lowest of their indices.
- R5: When T = 0, the result carries `out_zero` = 1, all scores are 0 and `out_class` is 0. A later non-zero input gives `out_zero` = 0.
- R6: `out_valid` is high for exactly one cycle per accepted input. It rises 14 rising edges after the edge that samples `in_valid` high. Inputs on consecutive cycles give results on consecutive cycles, in order.
- R7: While `rst` is high, `out_valid`, `out_zero`, `out_class` and `out_score` are all 0.
- R8: For T > 0, the seven scores add up to a value from 4090 to 4096 inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_act` as a new activation vector |
| in_act | input | 352 | 22 unsigned 16-bit activations, lane k at bits [16k+15:16k] |
| out_valid | output | 1 | One-cycle strobe marking a result |
| out_zero | output | 1 | Result came from an all-zero input; scores forced to 0 |
| out_class | output | 3 | Decided class code, 0–6 |
| out_score | output | 91 | Seven 13-bit normalised scores, class j at bits [13j+12:13j] |

## Verification
The two functions that can meet in the same cycle are the maximum search and the tie rule. Two classes can end up with equal shares in one result, and the lowest-index rule must then override the plain comparison. The bench builds vectors in which two whole classes have identical sums, once between classes 0 and 2 and once between classes 5 and 6. It judges each result against a reference that computes the floored shares and picks the first maximum. A separate case places the zero-total path right before a normal vector, back to back. This shows that the zero flag and its forced scores do not leak into the following result.

// File: rtl/pnn_sum_pkg.sv
package pnn_sum_pkg;
  localparam int N_HID = 22;
  localparam int N_CLS = 7;
  localparam int CLS_W = 3;

  typedef logic [CLS_W-1:0] cls_t;

  // first hidden lane of every class, then one past the last lane
  localparam int GRP_FIRST [N_CLS+1] = '{0, 1, 7, 9, 12, 16, 20, 22};
endpackage

// File: rtl/pnn_class_adder.sv
module pnn_class_adder
  import pnn_sum_pkg::*;
#(
  parameter int ACT_W = 16,
  parameter int SUM_W = ACT_W + $clog2(N_HID)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [N_HID*ACT_W-1:0]   act_flat,
  output logic [N_CLS*SUM_W-1:0]   sum_flat,
  output logic [SUM_W-1:0]         total,
  output logic                     sum_valid,
  output logic                     sum_zero
);

  logic [SUM_W-1:0] csum [N_CLS];
  logic [SUM_W-1:0] total_c;

  // one adder chain per class over its contiguous lanes
  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    localparam int FIRST = GRP_FIRST[c];
    localparam int CNT   = GRP_FIRST[c+1] - GRP_FIRST[c];
    always_comb begin
      csum[c] = '0;
      for (int i = 0; i < CNT; i++)
        csum[c] = csum[c] + SUM_W'(act_flat[(FIRST+i)*ACT_W +: ACT_W]);
    end
  end

  always_comb begin
    total_c = '0;
    for (int c = 0; c < N_CLS; c++)
      total_c = total_c + csum[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_valid <= 1'b0;
      sum_zero  <= 1'b0;
      total     <= '0;
      sum_flat  <= '0;
    end else begin
      sum_valid <= in_valid;
      sum_zero  <= (total_c == '0);
      total     <= total_c;
      for (int c = 0; c < N_CLS; c++)
        sum_flat[c*SUM_W +: SUM_W] <= csum[c];
    end
  end

endmodule

// File: rtl/pnn_frac_divider.sv
module pnn_frac_divider
  import pnn_sum_pkg::*;
#(
  parameter int SUM_W  = 21,
  parameter int FRAC_W = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic                        in_zero,
  input  logic [N_CLS*SUM_W-1:0]      num_flat,
  input  logic [SUM_W-1:0]            den,
  output logic                        out_valid,
  output logic                        out_zero,
  output logic [N_CLS*(FRAC_W+1)-1:0] quo_flat
);

  localparam int QUO_W  = FRAC_W + 1;
  localparam int REM_W  = SUM_W + 1;
  localparam int STAGES = QUO_W;

  // one restoring step per stage; numerator never exceeds the divisor
  for (genvar s = 0; s < STAGES; s++) begin : g_st
    localparam int BIT = FRAC_W - s;

    logic [REM_W-1:0] rem_r [N_CLS];
    logic [QUO_W-1:0] quo_r [N_CLS];
    logic [SUM_W-1:0] den_r;
    logic             vld_r;
    logic             zer_r;

    logic [REM_W-1:0] rem_i [N_CLS];
    logic [QUO_W-1:0] quo_i [N_CLS];
    logic [SUM_W-1:0] den_i;
    logic             vld_i;
    logic             zer_i;

    if (s == 0) begin : g_head
      always_comb begin
        for (int c = 0; c < N_CLS; c++) begin
          rem_i[c] = {1'b0, num_flat[c*SUM_W +: SUM_W]};
          quo_i[c] = '0;
        end
      end
      assign den_i = den;
      assign vld_i = in_valid;
      assign zer_i = in_zero;
    end else begin : g_link
      always_comb begin
        for (int c = 0; c < N_CLS; c++) begin
          rem_i[c] = g_st[s-1].rem_r[c];
          quo_i[c] = g_st[s-1].quo_r[c];
        end
      end
      assign den_i = g_st[s-1].den_r;
      assign vld_i = g_st[s-1].vld_r;
      assign zer_i = g_st[s-1].zer_r;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_r <= 1'b0;
        zer_r <= 1'b0;
        den_r <= '0;
        for (int c = 0; c < N_CLS; c++) begin
          rem_r[c] <= '0;
          quo_r[c] <= '0;
        end
      end else begin
        vld_r <= vld_i;
        zer_r <= zer_i;
        den_r <= den_i;
        for (int c = 0; c < N_CLS; c++) begin
          if (rem_i[c] >= {1'b0, den_i}) begin
            rem_r[c] <= (rem_i[c] - {1'b0, den_i}) << 1;
            quo_r[c] <= quo_i[c] | (QUO_W'(1) << BIT);
          end else begin
            rem_r[c] <= rem_i[c] << 1;
            quo_r[c] <= quo_i[c];
          end
        end
      end
    end

    // R2: partial remainder stays below twice the divisor at every step
    for (genvar c = 0; c < N_CLS; c++) begin : g_chk
      a_r2_rem_bound: assert property (@(posedge clk) disable iff (rst)
        (vld_r && !zer_r) |-> (rem_r[c] < {den_r, 1'b0}));
    end
  end

  assign out_valid = g_st[STAGES-1].vld_r;
  assign out_zero  = g_st[STAGES-1].zer_r;

  always_comb begin
    for (int c = 0; c < N_CLS; c++)
      quo_flat[c*QUO_W +: QUO_W] = g_st[STAGES-1].quo_r[c];
  end

endmodule

// File: rtl/pnn_argmax.sv
module pnn_argmax
  import pnn_sum_pkg::*;
#(
  parameter int SCORE_W = 13
) (
  input  logic [N_CLS*SCORE_W-1:0] score_flat,
  output cls_t                     best_idx
);

  logic [SCORE_W-1:0] best_val;

  // strict comparison keeps the earliest index on equal values
  always_comb begin
    best_idx = '0;
    best_val = score_flat[0 +: SCORE_W];
    for (int i = 1; i < N_CLS; i++) begin
      if (score_flat[i*SCORE_W +: SCORE_W] > best_val) begin
        best_val = score_flat[i*SCORE_W +: SCORE_W];
        best_idx = cls_t'(i);
      end
    end
  end

endmodule

// File: rtl/pnn_class_decide.sv
module pnn_class_decide
  import pnn_sum_pkg::*;
#(
  parameter int ACT_W  = 16,
  parameter int FRAC_W = 12,
  localparam int SUM_W   = ACT_W + $clog2(N_HID),
  localparam int SCORE_W = FRAC_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [N_HID*ACT_W-1:0]     in_act,
  output logic                       out_valid,
  output logic                       out_zero,
  output logic [CLS_W-1:0]           out_class,
  output logic [N_CLS*SCORE_W-1:0]   out_score
);

  localparam int TOT_W = SCORE_W + CLS_W;

  logic [N_CLS*SUM_W-1:0]   sum_flat;
  logic [SUM_W-1:0]         total;
  logic                     sum_valid;
  logic                     sum_zero;
  logic                     div_valid;
  logic                     div_zero;
  logic [N_CLS*SCORE_W-1:0] quo_flat;
  logic [N_CLS*SCORE_W-1:0] masked;
  cls_t                     best;

  pnn_class_adder #(.ACT_W(ACT_W), .SUM_W(SUM_W)) u_adder (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .act_flat  (in_act),
    .sum_flat  (sum_flat),
    .total     (total),
    .sum_valid (sum_valid),
    .sum_zero  (sum_zero)
  );

  pnn_frac_divider #(.SUM_W(SUM_W), .FRAC_W(FRAC_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (sum_valid),
    .in_zero   (sum_zero),
    .num_flat  (sum_flat),
    .den       (total),
    .out_valid (div_valid),
    .out_zero  (div_zero),
    .quo_flat  (quo_flat)
  );

  // a zero divisor leaves the quotients meaningless: replace them
  assign masked = div_zero ? '0 : quo_flat;

  pnn_argmax #(.SCORE_W(SCORE_W)) u_argmax (
    .score_flat (masked),
    .best_idx   (best)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_zero  <= 1'b0;
      out_class <= '0;
      out_score <= '0;
    end else begin
      out_valid <= div_valid;
      out_zero  <= div_zero;
      if (div_valid) begin
        out_class <= best;
        out_score <= masked;
      end
    end
  end

  // checks on the registered result
  logic               max_ok;
  logic               tie_ok;
  logic               lim_ok;
  logic [TOT_W-1:0]   score_total;
  logic [SCORE_W-1:0] chosen;

  always_comb begin
    max_ok      = 1'b1;
    tie_ok      = 1'b1;
    lim_ok      = 1'b1;
    score_total = '0;
    chosen      = '0;
    for (int i = 0; i < N_CLS; i++)
      if (cls_t'(i) == out_class) chosen = out_score[i*SCORE_W +: SCORE_W];
    for (int i = 0; i < N_CLS; i++) begin
      if (out_score[i*SCORE_W +: SCORE_W] > chosen) max_ok = 1'b0;
      if ((cls_t'(i) < out_class) && (out_score[i*SCORE_W +: SCORE_W] == chosen)) tie_ok = 1'b0;
      if (out_score[i*SCORE_W +: SCORE_W] > SCORE_W'(1 << FRAC_W)) lim_ok = 1'b0;
      score_total = score_total + TOT_W'(out_score[i*SCORE_W +: SCORE_W]);
    end
  end

  a_r3_code_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_class < cls_t'(N_CLS)));

  a_r3_class_is_max: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> max_ok);

  a_r4_lowest_on_tie: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> tie_ok);

  a_r2_score_limit: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> lim_ok);

  a_r5_zero_outputs: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_zero) |-> ((out_score == '0) && (out_class == '0)));

  a_r8_score_total: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_zero) |->
      ((score_total <= TOT_W'(1 << FRAC_W)) &&
       (score_total + TOT_W'(N_CLS) > TOT_W'(1 << FRAC_W))));

endmodule

// File: tb/pnn_class_decide_tb.sv
module pnn_class_decide_tb;

  localparam int ACT_W  = 16;
  localparam int FRAC_W = 12;
  localparam int NH     = 22;
  localparam int NC     = 7;
  localparam int SCW    = FRAC_W + 1;
  localparam int LAT    = FRAC_W + 2;

  typedef int unsigned vec_t [NH];

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic [NH*ACT_W-1:0] in_act = '0;
  logic               out_valid;
  logic               out_zero;
  logic [2:0]         out_class;
  logic [NC*SCW-1:0]  out_score;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pnn_class_decide #(.ACT_W(ACT_W), .FRAC_W(FRAC_W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_act    (in_act),
    .out_valid (out_valid),
    .out_zero  (out_zero),
    .out_class (out_class),
    .out_score (out_score)
  );

  function automatic int grp_of(int k);
    if (k == 0)  return 0;
    if (k <= 6)  return 1;
    if (k <= 8)  return 2;
    if (k <= 11) return 3;
    if (k <= 15) return 4;
    if (k <= 19) return 5;
    return 6;
  endfunction

  task automatic check(bit ok, string tag, string what, longint got, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic logic [NH*ACT_W-1:0] pack(vec_t v);
    logic [NH*ACT_W-1:0] p;
    p = '0;
    for (int k = 0; k < NH; k++) p[k*ACT_W +: ACT_W] = v[k][ACT_W-1:0];
    return p;
  endfunction

  task automatic compare_out(vec_t v, string tag);
    longint s [NC];
    longint t, e, sc_sum;
    longint exp_sc [NC];
    int best;
    t = 0;
    for (int j = 0; j < NC; j++) s[j] = 0;
    for (int k = 0; k < NH; k++) begin
      s[grp_of(k)] += v[k];
      t += v[k];
    end
    best = 0;
    sc_sum = 0;
    for (int j = 0; j < NC; j++) begin
      exp_sc[j] = (t == 0) ? 0 : ((s[j] << FRAC_W) / t);
      sc_sum += exp_sc[j];
    end
    for (int j = 1; j < NC; j++)
      if (exp_sc[j] > exp_sc[best]) best = j;
    check(out_valid == 1'b1, tag, "R6 out_valid", out_valid, 1);
    check(out_zero == (t == 0), tag, "R5 out_zero", out_zero, (t == 0));
    check(out_class == best[2:0], tag, "R3 out_class", out_class, best);
    for (int j = 0; j < NC; j++) begin
      e = exp_sc[j];
      check(longint'(out_score[j*SCW +: SCW]) == e, tag, $sformatf("R2 score %0d", j),
            out_score[j*SCW +: SCW], e);
    end
    if (t != 0)
      check(sc_sum <= 4096 && sc_sum >= 4090, tag, "R8 score sum", sc_sum, 4096);
  endtask

  task automatic send_and_check(vec_t v, string tag);
    @(negedge clk);
    in_act   = pack(v);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, tag, "R6 early out_valid", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    compare_out(v, tag);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, tag, "R6 single strobe", out_valid, 0);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R7", "out_valid", out_valid, 0);
    check(out_zero == 1'b0, "R7", "out_zero", out_zero, 0);
    check(out_class == 3'd0, "R7", "out_class", out_class, 0);
    check(out_score == '0, "R7", "out_score nonzero", (out_score != '0), 0);
  endtask

  task automatic t_node_map();
    vec_t v;
    for (int k = 0; k < NH; k++) begin
      for (int i = 0; i < NH; i++) v[i] = 0;
      v[k] = 1000 + k;
      send_and_check(v, $sformatf("R1 lane %0d", k));
    end
  endtask

  task automatic t_patterns();
    vec_t v;
    for (int i = 0; i < NH; i++) v[i] = 100;
    send_and_check(v, "R2 uniform");
    for (int i = 0; i < NH; i++) v[i] = i * 37 + 5;
    send_and_check(v, "R3 ramp");
    for (int i = 0; i < NH; i++) v[i] = 65535;
    send_and_check(v, "R2 full scale");
    for (int i = 0; i < NH; i++) v[i] = (i == 21) ? 65535 : 1;
    send_and_check(v, "R3 fusion dominant");
  endtask

  task automatic t_ties();
    vec_t v;
    for (int i = 0; i < NH; i++) v[i] = 0;
    v[0] = 300; v[7] = 150; v[8] = 150;
    send_and_check(v, "R4 tie normal-atrial");
    for (int i = 0; i < NH; i++) v[i] = 0;
    for (int i = 16; i < 20; i++) v[i] = 50;
    v[20] = 100; v[21] = 100;
    send_and_check(v, "R4 tie paced-fusion");
  endtask

  task automatic t_zero();
    vec_t v;
    for (int i = 0; i < NH; i++) v[i] = 0;
    send_and_check(v, "R5 zero total");
    v[3] = 7;
    send_and_check(v, "R5 after zero");
  endtask

  task automatic t_back_to_back();
    vec_t a, b, c;
    for (int i = 0; i < NH; i++) begin
      a[i] = 0;
      b[i] = (i % 3) * 211 + 9;
      c[i] = (i >= 12 && i <= 15) ? 4000 : 10;
    end
    @(negedge clk);
    in_act = pack(a); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_act = pack(b);
    @(posedge clk);
    @(negedge clk);
    in_act = pack(c);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT - 3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R6 burst", "early out_valid", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    compare_out(a, "R6 burst first");
    @(posedge clk);
    @(negedge clk);
    compare_out(b, "R6 burst second");
    @(posedge clk);
    @(negedge clk);
    compare_out(c, "R6 burst third");
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R6 burst", "strobe after burst", out_valid, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_node_map();
    t_patterns();
    t_ties();
    t_zero();
    t_back_to_back();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule